// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-side state machine of a 16-bit processor that shares one set of pins between address and data. A core-side port offers one transfer at a time: a 3-bit cycle code, a 20-bit address, write data and a high-byte enable. The sequencer walks each accepted transfer through the clock states T1, T2, T3, any number of wait states TW, and T4. On the way it drives the address latch pulse, the read, write and interrupt-acknowledge strobes, the data-transceiver enable and direction, the memory/IO select and the status code.

A slow device stretches a transfer by holding READY low. Another bus master can take the bus with HOLD. The sequencer answers with HLDA and drops the output enables of every bus group except the latch pulse. Tri-state behaviour is shown as two enable outputs, `bus_ad_oe` for the shared lines and `ctl_oe` for the control group, so no bidirectional nets are needed.

The states are ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4 and ST_HOLD. The transitions are:
- IDLE→T1 on an accepted request, and IDLE→HOLD on HOLD.
- T1→T2 and T2→T3.
- T3→T4 or TW→T4 when READY is high, and T3→TW or TW→TW when it is low.
- T4→T1 on an accepted request, T4→HOLD on HOLD, and T4→IDLE otherwise.
- HOLD→IDLE once HOLD is low.

Top module: `bcs_bus_sequencer`

## Requirements
- R1: While reset is applied, the block is idle. `ale`=0, `rd_n`=`wr_n`=`inta_n`=`den_n`=1, `stat`=111, `hlda`=0, `ctl_oe`=1 and `bus_ad_oe`=0.
- R2: `req_take` is high only in IDLE or T4, with HOLD low, `req_valid` high and a cycle code other than 011 (halt) or 111 (passive). A request with code 011 or 111 is ignored and no ALE pulse follows it.
- R3: In T1, `ale`=1 and `bus_ad_out` carries address bits 15:0 with `bus_ad_oe`=1. `bus_a_hi` carries address bits 19:16 for memory codes (code bit 2 = 1) and 0 for other codes. `bhe_n` equals the requested value.
- R4: For read codes 001, 100 and 101, `rd_n` is 0 in T2, T3 and TW. For code 000 (interrupt acknowledge), `inta_n` is 0 in those states. In both cases `bus_ad_oe` is 0 from T2 to T4, and `rd_data` in T4 holds `bus_ad_in` as sampled on the edge that ends the last T3/TW.
- R5: For write codes 010 and 110, `wr_n` is 0 in T2, T3 and TW. `bus_ad_oe` is 1 and `bus_ad_out` equals the write data from T2 to T4.
- R6: Every clock edge in T3 or TW with READY low adds one TW. T4 (`cyc_done`=1) follows only an edge with READY high.
- R7: `stat` shows the cycle code in T1 and T2. It shows 111 in T3, TW, T4 and IDLE, except in a T4 that accepts a new request, where it already shows the new code.
- R8: `dtr` is 1 for write codes and 0 otherwise. `mio` equals code bit 2. Both hold from T1 through the cycle's T4, and both already show the next cycle in a T4 that accepts one.
- R9: `den_n` is 0 in T2, T3 and TW of every cycle, and 1 in T1 and T4.
- R10: When HOLD is high in IDLE or T4, the next state is HOLD. There `hlda`=1, `ctl_oe`=0 and `bus_ad_oe`=0, while `ale` stays driven at 0. One clock after HOLD goes low, `hlda` is 0 and a pending request is accepted.
- R11: A request accepted in T4 moves the sequencer straight to T1 on the next clock, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_code | input | 3 | Cycle code (status encoding) |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_bhe_n | input | 1 | High-byte enable, active low |
| req_take | output | 1 | Request accepted this clock |
| ready | input | 1 | Device ready, low adds wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| bus_ad_out | output | DW | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Output enable of the shared lines |
| bus_ad_in | input | DW | Shared lines, received value |
| bus_a_hi | output | AW-DW | Upper address lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| den_n | output | 1 | Transceiver enable |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | 1 = memory, 0 = IO |
| bhe_n | output | 1 | High-byte enable |
| stat | output | 3 | Cycle status code |
| ctl_oe | output | 1 | Output enable of the control group |
| cyc_done | output | 1 | High in T4 |
| rd_data | output | DW | Captured read data |

## Verification
The bench goes after wait-state stretching with zero to three wait clocks. A design that samples READY one clock late would show `cyc_done` inside a wait clock or capture stale read data. It checks that codes 011 and 111 start no cycle, which a design that accepts any code would get wrong with a stray ALE pulse. It chains two cycles through T4 to catch a design that inserts an idle clock or previews the wrong status and direction. It raises HOLD both in IDLE and in T4 with a request pending, to catch a design that starts the cycle anyway or leaves the control group enabled while `hlda` is high.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_HOLD
    } bcs_state_e;

    localparam logic [2:0] CODE_INTA    = 3'b000;
    localparam logic [2:0] CODE_IORD    = 3'b001;
    localparam logic [2:0] CODE_IOWR    = 3'b010;
    localparam logic [2:0] CODE_HALT    = 3'b011;
    localparam logic [2:0] CODE_FETCH   = 3'b100;
    localparam logic [2:0] CODE_MRD     = 3'b101;
    localparam logic [2:0] CODE_MWR     = 3'b110;
    localparam logic [2:0] CODE_PASSIVE = 3'b111;

    function automatic logic code_is_write(input logic [2:0] c);
        return (c == CODE_IOWR) || (c == CODE_MWR);
    endfunction

    function automatic logic code_runs_cycle(input logic [2:0] c);
        return (c != CODE_HALT) && (c != CODE_PASSIVE);
    endfunction

endpackage

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  bcs_state_e        state,
    input  logic [2:0]        cur_code,
    input  logic [AW-1:0]     cur_addr,
    input  logic [DW-1:0]     cur_wdata,
    input  logic              cur_bhe_n,
    input  logic              nxt_take,
    input  logic [2:0]        nxt_code,
    output logic [DW-1:0]     bus_ad_out,
    output logic              bus_ad_oe,
    output logic [AW-DW-1:0]  bus_a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              den_n,
    output logic              dtr,
    output logic              mio,
    output logic              bhe_n,
    output logic [2:0]        stat,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              cyc_done
);
    logic is_wr;
    logic strobe_win;
    logic data_phase;
    logic preview;

    always_comb begin
        is_wr      = code_is_write(cur_code);
        strobe_win = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
        data_phase = strobe_win || (state == ST_T4);
        preview    = (state == ST_T4) && nxt_take;

        ale      = (state == ST_T1);
        hlda     = (state == ST_HOLD);
        ctl_oe   = (state != ST_HOLD);
        cyc_done = (state == ST_T4);

        bus_ad_oe = (state == ST_T1) || (is_wr && data_phase);
        if (state == ST_T1)
            bus_ad_out = cur_addr[DW-1:0];
        else if (is_wr && data_phase)
            bus_ad_out = cur_wdata;
        else
            bus_ad_out = '0;

        bus_a_hi = ((state == ST_T1) && cur_code[2]) ? cur_addr[AW-1:DW] : '0;
        bhe_n    = (state == ST_T1) ? cur_bhe_n : 1'b1;

        rd_n   = !(strobe_win && !is_wr && (cur_code != CODE_INTA));
        inta_n = !(strobe_win && (cur_code == CODE_INTA));
        wr_n   = !(strobe_win && is_wr);
        den_n  = !strobe_win;

        if ((state == ST_T1) || (state == ST_T2))
            stat = cur_code;
        else if (preview)
            stat = nxt_code;
        else
            stat = CODE_PASSIVE;

        dtr = preview ? code_is_write(nxt_code) : is_wr;
        mio = preview ? nxt_code[2] : cur_code[2];
    end
endmodule

// File: rtl/bcs_bus_sequencer.sv
module bcs_bus_sequencer
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_bhe_n,
    output logic              req_take,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda,
    output logic [DW-1:0]     bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DW-1:0]     bus_ad_in,
    output logic [AW-DW-1:0]  bus_a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              den_n,
    output logic              dtr,
    output logic              mio,
    output logic              bhe_n,
    output logic [2:0]        stat,
    output logic              ctl_oe,
    output logic              cyc_done,
    output logic [DW-1:0]     rd_data
);
    bcs_state_e      state_q, state_d;
    logic [2:0]      cur_code;
    logic [AW-1:0]   cur_addr;
    logic [DW-1:0]   cur_wdata;
    logic            cur_bhe_n;
    logic            open_slot;
    logic            end_wait;

    always_comb begin
        open_slot = (state_q == ST_IDLE) || (state_q == ST_T4);
        req_take  = open_slot && !hold && req_valid && code_runs_cycle(req_code);
        end_wait  = ((state_q == ST_T3) || (state_q == ST_TW)) && ready;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_T4: begin
                if (hold)          state_d = ST_HOLD;
                else if (req_take) state_d = ST_T1;
                else               state_d = ST_IDLE;
            end
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3,
            ST_TW:   state_d = ready ? ST_T4 : ST_TW;
            ST_HOLD: state_d = hold ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_code  <= CODE_PASSIVE;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_bhe_n <= 1'b1;
            rd_data   <= '0;
        end else begin
            state_q <= state_d;
            if (req_take) begin
                cur_code  <= req_code;
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_bhe_n <= req_bhe_n;
            end
            if (end_wait && !code_is_write(cur_code))
                rd_data <= bus_ad_in;
        end
    end

    bcs_strobe_dec #(.AW(AW), .DW(DW)) u_dec (
        .state      (state_q),
        .cur_code   (cur_code),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .cur_bhe_n  (cur_bhe_n),
        .nxt_take   (req_take),
        .nxt_code   (req_code),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_a_hi   (bus_a_hi),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .inta_n     (inta_n),
        .den_n      (den_n),
        .dtr        (dtr),
        .mio        (mio),
        .bhe_n      (bhe_n),
        .stat       (stat),
        .ctl_oe     (ctl_oe),
        .hlda       (hlda),
        .cyc_done   (cyc_done)
    );

    // R6
    wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && !ready) |=> (!cyc_done && !den_n));

    // R10
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctl_oe && !bus_ad_oe && !ale));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);

    // R3
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n && den_n));

    // R7
    passive_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T3) |-> (stat == CODE_PASSIVE));

    // R11
    chain_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && req_take) |=> ale);
endmodule

// File: tb/test_bcs_bus_sequencer.sv
`timescale 1ns/1ps
module test_bcs_bus_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_bhe_n, req_take, ready, hold, hlda;
    logic [2:0]  req_code, stat;
    logic [19:0] req_addr;
    logic [15:0] req_wdata, bus_ad_out, bus_ad_in, rd_data;
    logic [3:0]  bus_a_hi;
    logic        bus_ad_oe, ale, rd_n, wr_n, inta_n, den_n, dtr, mio, bhe_n, ctl_oe, cyc_done;

    int compared = 0;
    int mismatched = 0;

    logic [2:0]  e_code, n_code;
    logic [19:0] e_addr, n_addr;
    logic [15:0] e_wd, n_wd, e_rdata;
    logic        e_bhe, n_bhe;

    always #10 clk = ~clk;

    bcs_bus_sequencer i_bcs_bus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bhe_n(req_bhe_n),
        .req_take(req_take), .ready(ready), .hold(hold), .hlda(hlda),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_a_hi(bus_a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
        .den_n(den_n), .dtr(dtr), .mio(mio), .bhe_n(bhe_n), .stat(stat),
        .ctl_oe(ctl_oe), .cyc_done(cyc_done), .rd_data(rd_data)
    );

    function automatic logic f_wr(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b110);
    endfunction

    function automatic logic [2:0] f_pick_code(input int unsigned r);
        case (r % 6)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b010;
            3: return 3'b100;
            4: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pick_e();
        e_code = f_pick_code($urandom);
        e_addr = 20'($urandom);
        e_wd   = 16'($urandom);
        e_bhe  = 1'($urandom);
    endtask

    task automatic drive_e();
        req_valid = 1'b1;
        req_code  = e_code;
        req_addr  = e_addr;
        req_wdata = e_wd;
        req_bhe_n = e_bhe;
        #1;
    endtask

    task automatic body(input int nwait);
        logic w;
        logic exp_rd, exp_ia;
        w      = f_wr(e_code);
        exp_rd = !(!w && e_code != 3'b000);
        exp_ia = !(e_code == 3'b000);
        @(negedge clk); // T1
        chk("R3 ale", ale, 1);
        chk("R3 ad addr", bus_ad_out, e_addr[15:0]);
        chk("R3 ad oe", bus_ad_oe, 1);
        chk("R3 a_hi", bus_a_hi, e_code[2] ? e_addr[19:16] : 4'h0);
        chk("R3 bhe", bhe_n, e_bhe);
        chk("R7 stat T1", stat, e_code);
        chk("R8 dtr", dtr, w);
        chk("R8 mio", mio, e_code[2]);
        chk("R9 den T1", den_n, 1);
        req_valid = 1'b0;
        @(negedge clk); // T2
        chk("R4 rd T2", rd_n, exp_rd);
        chk("R4 inta T2", inta_n, exp_ia);
        chk("R5 wr T2", wr_n, !w);
        chk("R9 den T2", den_n, 0);
        chk("R7 stat T2", stat, e_code);
        chk("R5 ad oe T2", bus_ad_oe, w);
        if (w) chk("R5 ad data T2", bus_ad_out, e_wd);
        e_rdata   = 16'($urandom);
        bus_ad_in = e_rdata;
        @(negedge clk); // T3
        chk("R7 stat T3", stat, 3'b111);
        chk("R4 rd T3", rd_n, exp_rd);
        chk("R5 wr T3", wr_n, !w);
        chk("R9 den T3", den_n, 0);
        chk("R8 dtr T3", dtr, w);
        ready = (nwait == 0);
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk); // TW
            chk("R6 no done in TW", cyc_done, 0);
            chk("R6 strobe held TW", {rd_n, wr_n, inta_n}, {exp_rd, !w, exp_ia});
            chk("R7 stat TW", stat, 3'b111);
            chk("R9 den TW", den_n, 0);
            ready = (i == nwait - 1);
        end
        @(negedge clk); // T4
        chk("R6 done T4", cyc_done, 1);
        chk("R9 den T4", den_n, 1);
        chk("R4 strobes off T4", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R8 mio T4", mio, e_code[2]);
        if (w) begin
            chk("R5 ad oe T4", bus_ad_oe, 1);
            chk("R5 ad data T4", bus_ad_out, e_wd);
        end else begin
            chk("R4 ad oe T4", bus_ad_oe, 0);
            chk("R4 rd_data", rd_data, e_rdata);
        end
        ready = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        rst_n = 1'b0; ready = 1'b1; hold = 1'b0; req_valid = 1'b0;
        req_code = 3'b111; req_addr = '0; req_wdata = '0; req_bhe_n = 1'b1; bus_ad_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 ale", ale, 0);
        chk("R1 strobes", {rd_n, wr_n, inta_n, den_n}, 4'hF);
        chk("R1 stat", stat, 3'b111);
        chk("R1 hlda", hlda, 0);
        chk("R1 oe", {ctl_oe, bus_ad_oe}, 2'b10);
        rst_n = 1'b1;

        // R2: halt and passive codes start nothing
        @(negedge clk);
        req_valid = 1'b1; req_code = 3'b011; #1;
        chk("R2 halt not taken", req_take, 0);
        @(negedge clk);
        chk("R2 no ale after halt", ale, 0);
        req_code = 3'b111; #1;
        chk("R2 passive not taken", req_take, 0);
        @(negedge clk);
        chk("R2 no ale after passive", ale, 0);
        chk("R7 stat idle", stat, 3'b111);
        req_valid = 1'b0;

        // random cycles
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R7 stat idle", stat, 3'b111);
            pick_e();
            drive_e();
            chk("R2 take idle", req_take, 1);
            body(int'($urandom % 4));
        end

        // R11 back-to-back through T4
        @(negedge clk);
        pick_e(); e_code = 3'b101; drive_e();
        chk("R2 take", req_take, 1);
        body(1);
        n_code = 3'b010; n_addr = 20'hA5C3E; n_wd = 16'h1234; n_bhe = 1'b0;
        e_code = n_code; e_addr = n_addr; e_wd = n_wd; e_bhe = n_bhe;
        drive_e();
        chk("R11 take in T4", req_take, 1);
        chk("R7 stat preview T4", stat, n_code);
        chk("R8 dtr preview T4", dtr, 1);
        chk("R8 mio preview T4", mio, 0);
        body(0);

        // R10 hold from idle with pending request
        @(negedge clk);
        hold = 1'b1;
        pick_e(); drive_e();
        chk("R10 no take under hold", req_take, 0);
        @(negedge clk);
        chk("R10 hlda", hlda, 1);
        chk("R10 ctl float", ctl_oe, 0);
        chk("R10 ad float", bus_ad_oe, 0);
        chk("R10 ale driven low", ale, 0);
        chk("R10 no take in hold", req_take, 0);
        hold = 1'b0; #1;
        @(negedge clk);
        chk("R10 hlda released", hlda, 0);
        chk("R10 ctl back", ctl_oe, 1);
        chk("R10 take after release", req_take, 1);
        body(2);

        // R10 hold raised in T4
        hold = 1'b1;
        pick_e(); drive_e();
        chk("R10 no take T4 hold", req_take, 0);
        @(negedge clk);
        chk("R10 hlda after T4", hlda, 1);
        chk("R10 no ale", ale, 0);
        hold = 1'b0; #1;
        @(negedge clk);
        chk("R10 hlda low", hlda, 0);
        chk("R10 take", req_take, 1);
        body(0);

        @(negedge clk);
        chk("R7 stat end", stat, 3'b111);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule